// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one warp-wide load request and turns it into the smallest set of 32-byte sector fetches. A request carries a byte address for each of 32 lanes, a mask of active lanes, an access size code and a mode bit. It is accepted under a valid/ready handshake. The block works out which 32-byte sectors the active lanes touch and groups those sectors by 128-byte line. It then emits one transaction per line, one per clock cycle. Each transaction carries the line address and a 4-bit mask of the sectors needed in that line. When the request completes, a done pulse reports the total number of sectors issued and an error flag.

In the default mode the whole warp is merged, so lanes that hit the same sectors in any order cost nothing extra. The legacy mode handles the warp as two half-warps of 16 lanes, lanes 0-15 first and then lanes 16-31. A half-warp is merged only if its active lanes are sequential from an aligned base. Otherwise each of its active lanes is issued as a separate transaction. Cache lookup, data return and the DRAM side belong to other blocks.

Top module: `wmc_coalescer`

## Requirements
- R1: `req_ready` is 1 while the block holds no request. In the cycle after an accepting edge (`req_valid` and `req_ready` both 1) it is 0, and it is 1 again in the cycle where `done` is presented.
- R2: In default mode (`req_legacy`=0), the issued sectors are exactly the distinct 32-byte sectors (address bits [31:5]) touched by active lanes. Each transaction gives `tx_line` = address bits [31:7], and bit k of `tx_smask` requests the sector whose address bits [6:5] equal k. Reordering lanes among the same sectors changes nothing.
- R3: Transactions come out on consecutive cycles, with no gaps, starting the cycle after the accepting edge. In default mode each line appears once, in ascending line order. `tx_last` marks the final transaction and comes together with `done`.
- R4: Inactive lanes are ignored. A request with no active lane issues no transaction and presents `done` with `sector_total`=0 in the cycle after acceptance.
- R5: 32 lanes reading consecutive 4-byte words from a 128-byte aligned base give 4 sectors in one transaction. The same pattern shifted by 4 bytes gives 5 sectors.
- R6: A 4-byte access with a lane stride of 32 words or more puts every lane in its own sector, giving 32 sectors.
- R7: 16-byte accesses (size code 2) that are contiguous and aligned give 16 sectors.
- R8: Size codes are 0 = 4 bytes, 1 = 8 bytes, 2 = 16 bytes. Code 3, or code 2 with any active lane address not 16-byte aligned, issues no transaction and presents `err`=1 with `done` and `sector_total`=0.
- R9: In legacy mode, half-warp 0 (lanes 0-15) is issued completely before half-warp 1. A half-warp is merged (grouped by line, ascending) when every active lane i sits at B + (i mod 16)*size and B is a multiple of 16*size.
- R10: In legacy mode, a half-warp that fails the R9 test issues one transaction per active lane in ascending lane order. Each such transaction holds only that lane's sectors, even when another lane already requested them.
- R11: `sector_total` equals the sum of the set bits of all `tx_smask` values issued for the request.
- R12: An access whose bytes cross a 32-byte boundary touches both sectors, and if it crosses a 128-byte boundary it produces transactions for both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| req_size | input | 2 | Access size code (0: 4 B, 1: 8 B, 2: 16 B) |
| req_legacy | input | 1 | 1 selects half-warp legacy mode |
| tx_valid | output | 1 | Transaction present this cycle |
| tx_line | output | 25 | 128-byte line address (address bits [31:7]) |
| tx_smask | output | 4 | Sectors requested within the line |
| tx_last | output | 1 | Final transaction of the request |
| done | output | 1 | Request complete, one-cycle pulse |
| err | output | 1 | Request rejected (valid with done) |
| sector_total | output | 7 | Sectors issued for the request (valid with done) |

## Verification
Call the accepting clock edge edge 0. The first transaction is registered on edge 1, and transaction n on edge n. `done`, `err` and `sector_total` appear on the same edge as the last transaction, or on edge 1 when nothing is issued. `req_ready` is low from edge 1 until `done` is shown. The bench drives inputs and samples outputs only on falling edges. It therefore reads `req_ready` low at the first falling edge after acceptance. It then records one transaction per falling edge and requires `done` exactly at the falling edge numbered by the expected transaction count (or 1 for an empty request). The expected transaction list comes from a sector set that the bench sorts and groups itself.

// File: rtl/wmc_pkg.sv
`timescale 1ns/1ps
package wmc_pkg;

  typedef enum logic [1:0] {
    SZ_4   = 2'b00,
    SZ_8   = 2'b01,
    SZ_16  = 2'b10,
    SZ_BAD = 2'b11
  } size_code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // bytes moved per lane for a size code (0 for the reserved code)
  function automatic logic [5:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_4:    size_bytes = 6'd4;
      SZ_8:    size_bytes = 6'd8;
      SZ_16:   size_bytes = 6'd16;
      default: size_bytes = 6'd0;
    endcase
  endfunction

  // log2 of the lane access size
  function automatic logic [2:0] size_shift(input logic [1:0] code);
    case (code)
      SZ_8:    size_shift = 3'd3;
      SZ_16:   size_shift = 3'd4;
      default: size_shift = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/wmc_lane_decode.sv
`timescale 1ns/1ps
// Per-lane address decode: first sector touched, whether the access runs
// into the next sector, and whether a 16-byte access is misaligned.
module wmc_lane_decode #(
  parameter int ADDR_W    = 32,
  parameter int SECTOR_LG = 5
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [1:0]                  size_code,
  output logic [ADDR_W-SECTOR_LG-1:0] sec_first,
  output logic                        spans,
  output logic                        mis16
);
  import wmc_pkg::*;

  logic [ADDR_W-1:0] last_byte;

  always_comb begin
    last_byte = addr + ADDR_W'(size_bytes(size_code)) - ADDR_W'(1);
    sec_first = addr[ADDR_W-1:SECTOR_LG];
    spans     = (last_byte >> SECTOR_LG) != (addr >> SECTOR_LG);
    mis16     = (size_code == SZ_16) && (addr[3:0] != 4'h0);
  end

endmodule

// File: rtl/wmc_half_check.sv
`timescale 1ns/1ps
// Legacy test for one lane group: active lanes sequential from a base that
// is aligned to the group segment (GROUP * access size).
module wmc_half_check #(
  parameter int GROUP  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [GROUP*ADDR_W-1:0] addrs,
  input  logic [GROUP-1:0]        active,
  input  logic [1:0]              size_code,
  output logic                    seq_ok
);
  import wmc_pkg::*;

  localparam int GRP_LG = $clog2(GROUP);

  logic [2:0]        sh;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] seg_mask;
  logic              found;

  always_comb begin
    sh    = size_shift(size_code);
    found = 1'b0;
    base  = '0;
    for (int i = 0; i < GROUP; i++) begin
      if (active[i] && !found) begin
        base  = addrs[i*ADDR_W +: ADDR_W] - (ADDR_W'(i) << sh);
        found = 1'b1;
      end
    end
    seq_ok = 1'b1;
    for (int i = 0; i < GROUP; i++) begin
      if (active[i] && (addrs[i*ADDR_W +: ADDR_W] != base + (ADDR_W'(i) << sh)))
        seq_ok = 1'b0;
    end
    seg_mask = (ADDR_W'(1) << (32'(sh) + GRP_LG)) - ADDR_W'(1);
    if ((base & seg_mask) != '0)
      seq_ok = 1'b0;
  end

endmodule

// File: rtl/wmc_line_pick.sv
`timescale 1ns/1ps
// Finds the lowest line among pending in-scope sector entries and the
// sectors of that line; reports which entries it serves.
module wmc_line_pick #(
  parameter int LANES  = 32,
  parameter int SEC_W  = 27,
  parameter int SPL_LG = 2
) (
  input  logic [LANES*SEC_W-1:0]    sec_first,
  input  logic [LANES-1:0]          pend_a,
  input  logic [LANES-1:0]          pend_b,
  input  logic [LANES-1:0]          scope,
  output logic                      found,
  output logic [SEC_W-SPL_LG-1:0]   line,
  output logic [(1<<SPL_LG)-1:0]    smask,
  output logic [LANES-1:0]          hit_a,
  output logic [LANES-1:0]          hit_b
);
  localparam int LINE_W = SEC_W - SPL_LG;

  logic [SEC_W-1:0] sa [LANES];
  logic [SEC_W-1:0] sb [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_ent
    assign sa[g] = sec_first[g*SEC_W +: SEC_W];
    assign sb[g] = sa[g] + SEC_W'(1);
  end

  always_comb begin
    found = 1'b0;
    line  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (scope[i] && pend_a[i]) begin
        if (!found || (sa[i][SEC_W-1:SPL_LG] < line)) line = sa[i][SEC_W-1:SPL_LG];
        found = 1'b1;
      end
      if (scope[i] && pend_b[i]) begin
        if (!found || (sb[i][SEC_W-1:SPL_LG] < line)) line = sb[i][SEC_W-1:SPL_LG];
        found = 1'b1;
      end
    end
    smask = '0;
    hit_a = '0;
    hit_b = '0;
    for (int i = 0; i < LANES; i++) begin
      if (scope[i] && pend_a[i] && (sa[i][SEC_W-1:SPL_LG] == LINE_W'(line))) begin
        hit_a[i] = 1'b1;
        smask[sa[i][SPL_LG-1:0]] = 1'b1;
      end
      if (scope[i] && pend_b[i] && (sb[i][SEC_W-1:SPL_LG] == LINE_W'(line))) begin
        hit_b[i] = 1'b1;
        smask[sb[i][SPL_LG-1:0]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wmc_coalescer.sv
`timescale 1ns/1ps
module wmc_coalescer #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SECTOR_LG = 5,
  parameter int LINE_LG   = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [LANES*ADDR_W-1:0]             req_addr,
  input  logic [LANES-1:0]                    req_mask,
  input  logic [1:0]                          req_size,
  input  logic                                req_legacy,
  output logic                                tx_valid,
  output logic [ADDR_W-LINE_LG-1:0]           tx_line,
  output logic [(1<<(LINE_LG-SECTOR_LG))-1:0] tx_smask,
  output logic                                tx_last,
  output logic                                done,
  output logic                                err,
  output logic [$clog2(2*LANES+1)-1:0]        sector_total
);
  import wmc_pkg::*;

  localparam int SEC_W  = ADDR_W - SECTOR_LG;
  localparam int SPL_LG = LINE_LG - SECTOR_LG;
  localparam int SPL    = 1 << SPL_LG;
  localparam int LINE_W = ADDR_W - LINE_LG;
  localparam int CNT_W  = $clog2(2*LANES+1);
  localparam int HALF   = LANES / 2;

  // ---------------- request decode ----------------
  logic [LANES*SEC_W-1:0] dec_sec;
  logic [LANES-1:0]       dec_span;
  logic [LANES-1:0]       dec_mis;
  logic [1:0]             half_ok;
  logic                   bad_req;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wmc_lane_decode #(.ADDR_W(ADDR_W), .SECTOR_LG(SECTOR_LG)) u_dec (
      .addr      (req_addr[g*ADDR_W +: ADDR_W]),
      .size_code (req_size),
      .sec_first (dec_sec[g*SEC_W +: SEC_W]),
      .spans     (dec_span[g]),
      .mis16     (dec_mis[g])
    );
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    wmc_half_check #(.GROUP(HALF), .ADDR_W(ADDR_W)) u_chk (
      .addrs     (req_addr[h*HALF*ADDR_W +: HALF*ADDR_W]),
      .active    (req_mask[h*HALF +: HALF]),
      .size_code (req_size),
      .seq_ok    (half_ok[h])
    );
  end

  assign bad_req = (req_size == SZ_BAD) || ((dec_mis & req_mask) != '0);

  // ---------------- held request ----------------
  run_state_e             state;
  logic [LANES*SEC_W-1:0] sec_q;
  logic [LANES-1:0]       pa_q, pb_q;
  logic [1:0]             serial_q;
  logic                   legacy_q;
  logic                   err_q;
  logic [CNT_W-1:0]       cnt_q;

  // ---------------- named events ----------------
  logic accept;   // request taken this edge
  logic emit;     // a transaction is produced this edge
  logic finish;   // request completes this edge

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // ---------------- scope selection ----------------
  logic [LANES-1:0] pend_lane, half_sel, grp_pend, first_lane, scope;
  logic             lo_busy, ser_now;

  always_comb begin
    pend_lane  = pa_q | pb_q;
    lo_busy    = (pend_lane[HALF-1:0] != '0);
    half_sel   = lo_busy ? {{HALF{1'b0}}, {HALF{1'b1}}} : {{HALF{1'b1}}, {HALF{1'b0}}};
    grp_pend   = pend_lane & half_sel;
    first_lane = grp_pend & (~grp_pend + LANES'(1));
    ser_now    = lo_busy ? serial_q[0] : serial_q[1];
    if (!legacy_q)    scope = '1;
    else if (ser_now) scope = first_lane;
    else              scope = half_sel;
  end

  // ---------------- line selection ----------------
  logic              pick_found;
  logic [LINE_W-1:0] pick_line;
  logic [SPL-1:0]    pick_mask;
  logic [LANES-1:0]  hit_a, hit_b;

  wmc_line_pick #(.LANES(LANES), .SEC_W(SEC_W), .SPL_LG(SPL_LG)) u_pick (
    .sec_first (sec_q),
    .pend_a    (pa_q),
    .pend_b    (pb_q),
    .scope     (scope),
    .found     (pick_found),
    .line      (pick_line),
    .smask     (pick_mask),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
  );

  logic [LANES-1:0] pa_next, pb_next;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    pa_next  = pa_q & ~hit_a;
    pb_next  = pb_q & ~hit_b;
    cnt_next = cnt_q + CNT_W'($countones(pick_mask));
  end

  assign emit   = (state == ST_RUN) && pick_found;
  assign finish = (state == ST_RUN) && ((pa_next | pb_next) == '0);

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      sec_q        <= '0;
      pa_q         <= '0;
      pb_q         <= '0;
      serial_q     <= '0;
      legacy_q     <= 1'b0;
      err_q        <= 1'b0;
      cnt_q        <= '0;
      tx_valid     <= 1'b0;
      tx_line      <= '0;
      tx_smask     <= '0;
      tx_last      <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      sector_total <= '0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (accept) begin
        state    <= ST_RUN;
        sec_q    <= dec_sec;
        pa_q     <= bad_req ? '0 : req_mask;
        pb_q     <= bad_req ? '0 : (req_mask & dec_span);
        serial_q <= ~half_ok;
        legacy_q <= req_legacy;
        err_q    <= bad_req;
        cnt_q    <= '0;
      end else if (state == ST_RUN) begin
        if (emit) begin
          tx_valid <= 1'b1;
          tx_line  <= pick_line;
          tx_smask <= pick_mask;
          pa_q     <= pa_next;
          pb_q     <= pb_next;
          cnt_q    <= cnt_next;
        end
        if (finish) begin
          tx_last      <= emit;
          done         <= 1'b1;
          err          <= err_q;
          sector_total <= cnt_next;
          state        <= ST_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/wmc_checker.sv
`timescale 1ns/1ps
module wmc_checker #(
  parameter int LINE_W = 25,
  parameter int SPL    = 4,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_legacy,
  input logic              accept,
  input logic              emit,
  input logic              finish,
  input logic              tx_valid,
  input logic [LINE_W-1:0] tx_line,
  input logic [SPL-1:0]    tx_smask,
  input logic              tx_last,
  input logic              done,
  input logic              err,
  input logic [CNT_W-1:0]  sector_total
);
  logic              mode_leg;
  logic              seen;
  logic [LINE_W-1:0] prev_line;
  logic [CNT_W-1:0]  acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_leg  <= 1'b0;
      seen      <= 1'b0;
      prev_line <= '0;
      acc       <= '0;
    end else if (accept) begin
      mode_leg <= req_legacy;
      seen     <= 1'b0;
      acc      <= '0;
    end else if (tx_valid) begin
      seen      <= 1'b1;
      prev_line <= tx_line;
      acc       <= acc + CNT_W'($countones(tx_smask));
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  a_r1_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r1_no_tx_while_idle_early: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !done) |-> !req_ready);
  a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_smask != '0));
  a_r3_last_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && done));
  a_r3_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tx_valid);
  a_r3_emit_registered: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> tx_valid);
  a_r3_finish_registered: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done);
  a_r3_lines_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && seen && !mode_leg) |-> (tx_line > prev_line));
  a_r8_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (!tx_valid && !seen && (sector_total == '0)));
  a_r11_total_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sector_total == acc + (tx_valid ? CNT_W'($countones(tx_smask)) : CNT_W'(0))));

endmodule

bind wmc_coalescer wmc_checker #(
  .LINE_W (LINE_W),
  .SPL    (SPL),
  .CNT_W  (CNT_W)
) u_wmc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .req_legacy   (req_legacy),
  .accept       (accept),
  .emit         (emit),
  .finish       (finish),
  .tx_valid     (tx_valid),
  .tx_line      (tx_line),
  .tx_smask     (tx_smask),
  .tx_last      (tx_last),
  .done         (done),
  .err          (err),
  .sector_total (sector_total)
);

// File: tb/tb_wmc_coalescer.sv
`timescale 1ns/1ps
module tb_wmc_coalescer;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1023:0] req_addr = '0;
  logic [31:0]   req_mask = '0;
  logic [1:0]    req_size = '0;
  logic          req_legacy = 1'b0;
  logic          tx_valid;
  logic [24:0]   tx_line;
  logic [3:0]    tx_smask;
  logic          tx_last;
  logic          done;
  logic          err;
  logic [6:0]    sector_total;

  always #2 clk = ~clk;

  wmc_coalescer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
    .req_legacy(req_legacy), .tx_valid(tx_valid), .tx_line(tx_line),
    .tx_smask(tx_smask), .tx_last(tx_last), .done(done), .err(err),
    .sector_total(sector_total)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint got, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] a  [32];
  logic [24:0] el [80];
  logic [3:0]  em [80];
  int          en, ecnt;
  bit          eerr;
  logic [26:0] sl [64];
  int          sn;

  task automatic add_sec(input logic [26:0] s);
    for (int k = 0; k < sn; k++) if (sl[k] == s) return;
    sl[sn] = s;
    sn++;
  endtask

  task automatic add_lane(input int i, input int sz);
    logic [31:0] e;
    e = a[i] + 32'(sz) - 32'd1;
    add_sec(a[i][31:5]);
    add_sec(e[31:5]);
  endtask

  task automatic flush();
    int gstart;
    logic [26:0] t;
    for (int i = 1; i < sn; i++) begin
      for (int j = i; j > 0; j--) begin
        if (sl[j] < sl[j-1]) begin t = sl[j]; sl[j] = sl[j-1]; sl[j-1] = t; end
      end
    end
    gstart = en;
    for (int i = 0; i < sn; i++) begin
      if (en > gstart && el[en-1] == sl[i][26:2]) em[en-1][sl[i][1:0]] = 1'b1;
      else begin
        el[en] = sl[i][26:2];
        em[en] = 4'b0;
        em[en][sl[i][1:0]] = 1'b1;
        en++;
      end
    end
    sn = 0;
  endtask

  task automatic build_expect(input logic [31:0] msk, input logic [1:0] code, input bit leg);
    int sz;
    bit ok;
    int rf;
    logic [31:0] base;
    en = 0; ecnt = 0; sn = 0;
    sz = 4 << code;
    eerr = (code == 2'd3);
    for (int i = 0; i < 32; i++) if (msk[i] && code == 2'd2 && a[i][3:0] != 4'h0) eerr = 1'b1;
    if (!eerr) begin
      if (!leg) begin
        for (int i = 0; i < 32; i++) if (msk[i]) add_lane(i, sz);
        flush();
      end else begin
        for (int h = 0; h < 2; h++) begin
          ok = 1'b1; rf = -1;
          for (int i = h*16; i < h*16+16; i++) begin
            if (msk[i]) begin
              if (rf < 0) rf = i;
              else if (a[i] != a[rf] + 32'((i-rf)*sz)) ok = 1'b0;
            end
          end
          if (rf >= 0) begin
            base = a[rf] - 32'((rf-h*16)*sz);
            if ((base % 32'(16*sz)) != 0) ok = 1'b0;
          end
          if (ok) begin
            for (int i = h*16; i < h*16+16; i++) if (msk[i]) add_lane(i, sz);
            flush();
          end else begin
            for (int i = h*16; i < h*16+16; i++) if (msk[i]) begin add_lane(i, sz); flush(); end
          end
        end
      end
    end
    for (int t = 0; t < en; t++) ecnt += $countones(em[t]);
  endtask

  // ---------------- one request ----------------
  task automatic run(input string rq, input logic [31:0] msk, input logic [1:0] code,
                     input bit leg, input int lit);
    logic [24:0] gl [80];
    logic [3:0]  gm [80];
    int  got_n, cyc, dcyc, gcnt;
    bit  gdone, gerr, gap, lastbad, gready, same;
    build_expect(msk, code, leg);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
    req_mask = msk; req_size = code; req_legacy = leg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    got_n = 0; cyc = 0; dcyc = 0; gdone = 0; gap = 0; lastbad = 0;
    gerr = 0; gcnt = 0; gready = 0;
    while (!gdone && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (tx_valid) begin
        if (got_n < 80) begin gl[got_n] = tx_line; gm[got_n] = tx_smask; end
        got_n++;
        if (tx_last != done) lastbad = 1'b1;
      end else if (!done) gap = 1'b1;
      if (done) begin
        gdone = 1'b1; dcyc = cyc; gerr = err; gcnt = int'(sector_total); gready = req_ready;
      end
    end
    chk(gdone, rq, "done seen", gdone, 1);
    same = (got_n == en);
    if (same) for (int t = 0; t < en; t++) if (gl[t] != el[t] || gm[t] != em[t]) same = 1'b0;
    chk(same, rq, "transaction list (count shown)", got_n, en);
    chk(!gap && !lastbad && dcyc == ((en == 0) ? 1 : en), "R3", "done cycle", dcyc,
        (en == 0) ? 1 : en);
    chk(gerr == eerr, "R8", "err flag", gerr, eerr);
    chk(gcnt == ecnt, "R11", "sector total", gcnt, ecnt);
    if (lit >= 0) chk(gcnt == lit, rq, "sector total literal", gcnt, lit);
    chk(gready == 1'b1, "R1", "ready with done", gready, 1);
  endtask

  task automatic fill(input logic [31:0] base, input int stride);
    for (int i = 0; i < 32; i++) a[i] = base + 32'(i*stride);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] msk;
    logic [1:0]  code;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(tx_valid == 1'b0 && done == 1'b0, "R1", "reset outputs", tx_valid, 0);
    rst_n = 1'b1;

    fill(32'h1000, 4);  run("R5", 32'hFFFF_FFFF, 2'd0, 1'b0, 4);
    fill(32'h1004, 4);  run("R5", 32'hFFFF_FFFF, 2'd0, 1'b0, 5);
    fill(32'h1000, 128); run("R6", 32'hFFFF_FFFF, 2'd0, 1'b0, 32);
    fill(32'h1000, 132); run("R6", 32'hFFFF_FFFF, 2'd0, 1'b0, 32);
    fill(32'h3000, 16); run("R7", 32'hFFFF_FFFF, 2'd2, 1'b0, 16);
    fill(32'h3000, 16); a[5] = a[5] + 8; run("R8", 32'hFFFF_FFFF, 2'd2, 1'b0, 0);
    fill(32'h3000, 16); run("R8", 32'hFFFF_FFFF, 2'd3, 1'b0, 0);
    fill(32'h3000, 16); a[5] = a[5] + 8; run("R4", 32'hFFFF_FFDF, 2'd2, 1'b0, 16);
    fill(32'h1000, 4);  run("R4", 32'h0000_0000, 2'd0, 1'b0, 0);
    fill(32'h1000, 4);  run("R4", 32'h5555_5555, 2'd0, 1'b0, 4);
    for (int i = 0; i < 32; i++) a[i] = 32'h1000 + 32'((31-i)*4);
    run("R2", 32'hFFFF_FFFF, 2'd0, 1'b0, 4);
    fill(32'h2004, 8);  run("R12", 32'hFFFF_FFFF, 2'd1, 1'b0, 9);
    fill(32'h207C, 0);  run("R12", 32'h0000_0001, 2'd1, 1'b0, 2);
    fill(32'h1000, 4);  run("R9", 32'hFFFF_FFFF, 2'd0, 1'b1, 4);
    fill(32'h1000, 4);  run("R9", 32'h0000_FFF0, 2'd0, 1'b1, 2);
    fill(32'h1004, 4);  run("R10", 32'hFFFF_FFFF, 2'd0, 1'b1, 32);
    fill(32'h1000, 4);  a[0] = 32'h1004; a[1] = 32'h1000;
    run("R10", 32'hFFFF_FFFF, 2'd0, 1'b1, 18);

    // sweep of strides, offsets, sizes and both modes
    for (int leg = 0; leg < 2; leg++)
      for (int c = 0; c < 3; c++)
        for (int sw = 0; sw <= 40; sw++)
          for (int o = 0; o < 4; o++) begin
            fill(32'h0004_0000 + 32'(o == 0 ? 0 : (o == 1 ? 4 : (o == 2 ? 16 : 28))), sw*4);
            run(leg ? "R9" : "R2", 32'hFFFF_FFFF, 2'(c), leg[0], -1);
          end

    // random requests
    for (int r = 0; r < 300; r++) begin
      code = 2'($urandom % 3);
      if (($urandom % 16) == 0) code = 2'd3;
      for (int i = 0; i < 32; i++) begin
        case (r % 3)
          0: a[i] = 32'h0008_0000 + (32'($urandom % 96) << ((code == 2'd3) ? 2 : code + 2));
          1: a[i] = 32'h0008_0000 + 32'((r % 8) * 4) + 32'(i * (4 << code));
          default: a[i] = 32'h0008_0000 + 32'(i * 4 * (1 + r % 40));
        endcase
      end
      if (($urandom % 8) == 0) a[$urandom % 32] += 4;
      msk = $urandom;
      if ((r % 5) == 0) msk = 32'hFFFF_FFFF;
      run((r % 2) ? "R10" : "R3", msk, code, r[1], -1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule